// File: doc/BRIEF.md
# Configuration Load and Startup Sequencer

This block walks a programmable device through its configuration life cycle. There are three phases, always in this order: the configuration memory is cleared, the configuration data is loaded, and a startup sequence then brings the device into operation. A cycle starts after power-up reset. It starts again whenever the restart request is raised. While clearing, the block pulls its INIT line low. It waits for the sensed INIT level to be high before it accepts data, so an outside agent that holds INIT low can stretch the clear phase.

Load data arrives as a valid/ready stream, one beat per clock. A beat transfers on a rising edge where `s_valid` and `s_ready` are both high. `s_ready` never depends on `s_valid`, and a source may hold `s_valid` high for as long as it likes. The block counts the configuration bits it receives against a parameterised total. Each beat carries 1 bit or 8 bits, depending on the mode the pins select. Only lane 0 of the data bus enters this block; the other lanes go straight to the memory. When the total is reached, the block pulses global reset and raises DONE. It then releases the output 3-state hold, and after that the write-enable hold. Optionally, each release waits for an external wired DONE. In the serial modes, beats that arrive after loading are passed through on a one-bit output, for the next device in a chain.

Top module: `cfg_life_seq`

## Requirements
- R1: During reset and in the clear phase, `init_drive_low`=1, `done`=0, `gsr_pulse`=0, `gts_hold`=1, `gwe_hold`=1 and `s_ready`=0.
- R2: The clear phase lasts exactly CLEAR_CYCLES clock cycles. After that, `init_drive_low` falls.
- R3: `s_ready` stays low while INIT is driven low, and also while `init_in` is sensed low. The load phase (`s_ready`=1) begins one cycle after `init_in` is seen high.
- R4: The mode pins set the bits per beat. Codes 000, 111 and 101 give 1 bit; codes 011 and 110 give 8 bits. The code is captured when loading begins, and pin changes have no effect until the next clear.
- R5: With mode code 001, 010 or 100, the block never accepts a load beat and never raises DONE.
- R6: Loading completes when the bit count reaches TOTAL_BITS, which takes ceil(TOTAL_BITS/width) beats. `s_ready` is low in the cycle after the final beat.
- R7: `gsr_pulse` is high for exactly one cycle, in the cycle after loading completes. `done` rises in the next cycle.
- R8: `gts_hold` falls one cycle after `done` rises. `gwe_hold` falls one cycle after that.
- R9: When `sync_start`=1, each of the two releases waits in place until `ext_done_in` is high.
- R10: A restart in any state sends the block to the clear phase on the next cycle. DONE drops, both holds go back up, and the bit count goes back to zero.
- R11: After loading, in modes 000 and 111, `s_ready`=1 and `s_data0` of each accepted beat appears on `thru_bit`, with `thru_valid`=1, one cycle later. In all other modes, `s_ready`=0 after loading.
- R12: `cclk_drive` is 1 for live mode pins 000 and 011, and 0 for all other codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| restart | input | 1 | Restart request, synchronous, active high |
| init_in | input | 1 | Sensed level of the wired INIT line |
| mode_pins | input | 3 | Load-style selection pins |
| s_valid | input | 1 | Load stream beat valid |
| s_ready | output | 1 | Load stream ready |
| s_data0 | input | 1 | Lane 0 of the load data bus |
| sync_start | input | 1 | Option: make the releases wait for the external DONE |
| ext_done_in | input | 1 | Sensed level of the wired external DONE |
| init_drive_low | output | 1 | Pull INIT low (open-drain enable) |
| gsr_pulse | output | 1 | Global set/reset pulse |
| done | output | 1 | Configuration complete |
| gts_hold | output | 1 | Keep the device outputs 3-stated |
| gwe_hold | output | 1 | Keep the storage write-enable blocked |
| thru_valid | output | 1 | Pass-through bit valid |
| thru_bit | output | 1 | Pass-through serial data |
| cclk_drive | output | 1 | Configuration clock pin is an output |

## Verification
The assertions take two things for granted. First, `restart` is sampled as a synchronous request. Second, `init_in` is the wired-AND of this block's own drive and any outside holder, so `init_in` is low whenever `init_drive_low` is high. The bench builds `init_in` exactly that way, from the block's drive and a bench-controlled holder. It changes the mode pins only outside the load window, except for one deliberate change during loading that tests R4. It changes `restart` and `ext_done_in` only at falling edges, so each request is seen as a whole cycle.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    PH_CLEAR,
    PH_HOLD,
    PH_LOAD,
    PH_GRESET,
    PH_DONE,
    PH_OUTON,
    PH_RUN
  } phase_t;

  localparam logic [2:0] MD_MSER  = 3'b000;
  localparam logic [2:0] MD_SSER  = 3'b111;
  localparam logic [2:0] MD_MBYTE = 3'b011;
  localparam logic [2:0] MD_SBYTE = 3'b110;
  localparam logic [2:0] MD_SCAN  = 3'b101;

  // bits carried per accepted beat; zero marks an unusable code
  function automatic logic [3:0] beat_bits(input logic [2:0] m);
    case (m)
      MD_MSER, MD_SSER, MD_SCAN: beat_bits = 4'd1;
      MD_MBYTE, MD_SBYTE:        beat_bits = 4'd8;
      default:                   beat_bits = 4'd0;
    endcase
  endfunction

  function automatic logic passes_surplus(input logic [2:0] m);
    passes_surplus = (m == MD_MSER) || (m == MD_SSER);
  endfunction

  function automatic logic drives_clock(input logic [2:0] m);
    drives_clock = (m == MD_MSER) || (m == MD_MBYTE);
  endfunction

endpackage

// File: rtl/cfg_clear_timer.sv
module cfg_clear_timer #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(CYCLES + 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || !run) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == TW'(CYCLES - 1));
endmodule

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter #(
  parameter int TOTAL_BITS = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       step,
  input  logic [3:0] width,
  output logic       complete
);
  localparam int CW = $clog2(TOTAL_BITS + 9);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= cnt + CW'(width);
  end

  assign complete = (cnt >= CW'(TOTAL_BITS));
endmodule

// File: rtl/cfg_surplus_fwd.sv
module cfg_surplus_fwd (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic bit_in,
  output logic thru_valid,
  output logic thru_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thru_valid <= 1'b0;
      thru_bit   <= 1'b0;
    end else begin
      thru_valid <= take;
      if (take) thru_bit <= bit_in;
    end
  end
endmodule

// File: rtl/cfg_life_seq.sv
module cfg_life_seq
  import cfg_seq_pkg::*;
#(
  parameter int CLEAR_CYCLES = 16,
  parameter int TOTAL_BITS   = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       init_in,
  input  logic [2:0] mode_pins,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic       s_data0,
  input  logic       sync_start,
  input  logic       ext_done_in,
  output logic       init_drive_low,
  output logic       gsr_pulse,
  output logic       done,
  output logic       gts_hold,
  output logic       gwe_hold,
  output logic       thru_valid,
  output logic       thru_bit,
  output logic       cclk_drive
);

  phase_t     phase, phase_nxt;
  logic [2:0] lat_mode;
  logic [3:0] width;
  logic       clr_expired;
  logic       load_complete;
  logic       take;
  logic       release_ok;
  logic       in_load;
  logic       after_load;

  // the clear timer restarts on any restart request, even inside the clear phase
  cfg_clear_timer #(.CYCLES(CLEAR_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (restart),
    .run     (phase == PH_CLEAR),
    .expired (clr_expired)
  );

  cfg_bit_counter #(.TOTAL_BITS(TOTAL_BITS)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (phase == PH_CLEAR),
    .step     (take && in_load),
    .width    (width),
    .complete (load_complete)
  );

  cfg_surplus_fwd u_fwd (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take && after_load),
    .bit_in     (s_data0),
    .thru_valid (thru_valid),
    .thru_bit   (thru_bit)
  );

  assign width      = beat_bits(lat_mode);
  assign release_ok = !sync_start || ext_done_in;
  assign in_load    = (phase == PH_LOAD);
  assign after_load = (phase == PH_GRESET) || (phase == PH_DONE) ||
                      (phase == PH_OUTON)  || (phase == PH_RUN);

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_CLEAR:  if (clr_expired)   phase_nxt = PH_HOLD;
      PH_HOLD:   if (init_in)       phase_nxt = PH_LOAD;
      PH_LOAD:   if (load_complete) phase_nxt = PH_GRESET;
      PH_GRESET:                    phase_nxt = PH_DONE;
      PH_DONE:   if (release_ok)    phase_nxt = PH_OUTON;
      PH_OUTON:  if (release_ok)    phase_nxt = PH_RUN;
      PH_RUN:                       phase_nxt = PH_RUN;
      default:                      phase_nxt = PH_CLEAR;
    endcase
    if (restart) phase_nxt = PH_CLEAR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CLEAR;
      lat_mode <= MD_MSER;
    end else begin
      phase <= phase_nxt;
      if (phase == PH_HOLD && init_in && !restart) lat_mode <= mode_pins;
    end
  end

  // ready depends on phase, count, mode and restart only, never on s_valid
  always_comb begin
    if (restart)         s_ready = 1'b0;
    else if (in_load)    s_ready = !load_complete && (width != 4'd0);
    else if (after_load) s_ready = passes_surplus(lat_mode);
    else                 s_ready = 1'b0;
  end

  assign take           = s_valid && s_ready;
  assign init_drive_low = (phase == PH_CLEAR);
  assign gsr_pulse      = (phase == PH_GRESET);
  assign done           = (phase == PH_DONE) || (phase == PH_OUTON) || (phase == PH_RUN);
  assign gts_hold       = !((phase == PH_OUTON) || (phase == PH_RUN));
  assign gwe_hold       = (phase != PH_RUN);
  assign cclk_drive     = drives_clock(mode_pins);

endmodule

// File: rtl/cfg_life_chk.sv
module cfg_life_chk (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic init_drive_low,
  input logic s_valid,
  input logic s_ready,
  input logic gsr_pulse,
  input logic done,
  input logic gts_hold,
  input logic gwe_hold,
  input logic thru_valid,
  input logic sync_start,
  input logic ext_done_in
);

  assert_clear_blocks_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    init_drive_low |-> !s_ready);

  assert_gsr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gsr_pulse && !restart) |=> (!gsr_pulse && done));

  assert_done_after_gsr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(gsr_pulse));

  assert_gts_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gts_hold) |-> (done && $past(done)));

  assert_gwe_after_gts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gwe_hold |-> !gts_hold);

  assert_sync_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_start && !ext_done_in && !restart && done && gts_hold) |=> gts_hold);

  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (init_drive_low && !done && gts_hold && gwe_hold));

  assert_thru_from_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    thru_valid |-> $past(s_valid && s_ready));

endmodule

bind cfg_life_seq cfg_life_chk u_chk (.*);

// File: tb/sim_cfg_life_seq.sv
module sim_cfg_life_seq;
  localparam int CLK_P = 10;
  localparam int CLR_N = 12;
  localparam int TOT   = 203;

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, agent_hold = 1'b0;
  logic [2:0] mode_pins = 3'b000;
  logic s_valid = 1'b0, s_data0 = 1'b0, sync_start = 1'b0, ext_done_in = 1'b0;
  logic s_ready, init_drive_low, gsr_pulse, done, gts_hold, gwe_hold;
  logic thru_valid, thru_bit, cclk_drive, init_in;
  int checks = 0, errors = 0;

  assign init_in = !(init_drive_low || agent_hold);
  always #(CLK_P/2) clk = ~clk;

  cfg_life_seq #(.CLEAR_CYCLES(CLR_N), .TOTAL_BITS(TOT)) u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .init_in(init_in),
    .mode_pins(mode_pins), .s_valid(s_valid), .s_ready(s_ready), .s_data0(s_data0),
    .sync_start(sync_start), .ext_done_in(ext_done_in), .init_drive_low(init_drive_low),
    .gsr_pulse(gsr_pulse), .done(done), .gts_hold(gts_hold), .gwe_hold(gwe_hold),
    .thru_valid(thru_valid), .thru_bit(thru_bit), .cclk_drive(cclk_drive));

  function automatic int exp_width(input logic [2:0] m);
    if (m == 3'b000 || m == 3'b111 || m == 3'b101) return 1;
    if (m == 3'b011 || m == 3'b110) return 8;
    return 0;
  endfunction
  function automatic int exp_beats(input logic [2:0] m);
    return (TOT + exp_width(m) - 1) / exp_width(m);
  endfunction
  function automatic int exp_serial(input logic [2:0] m);
    return (m == 3'b000 || m == 3'b111) ? 1 : 0;
  endfunction
  function automatic int exp_master(input logic [2:0] m);
    return (m == 3'b000 || m == 3'b011) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one configuration pass; abort>0 raises restart after that many beats
  task automatic run_cfg(input logic [2:0] m, input bit sync, input int hold,
                         input int ext_delay, input bit flip, input int abort,
                         input bit skip_restart);
    int n, acc, guard, bit_v;
    mode_pins = m; sync_start = sync; ext_done_in = 1'b0;
    agent_hold = (hold > 0);
    if (!skip_restart) begin
      @(negedge clk); restart = 1'b1;
      @(negedge clk); restart = 1'b0;
      chk("R10 init low after restart", int'(init_drive_low), 1);
      chk("R10 done dropped", int'(done), 0);
      chk("R10 holds up", int'(gts_hold && gwe_hold), 1);
    end
    chk("R12 clock direction", int'(cclk_drive), exp_master(m));
    n = 0;
    while (init_drive_low && n < 1000) begin
      if (n == 1) chk("R1 clear state", int'(s_ready || gsr_pulse || done), 0);
      n++; @(negedge clk);
    end
    chk("R2 clear length", n, CLR_N);
    for (int i = 0; i < hold; i++) begin
      chk("R3 no load while INIT held", int'(s_ready), 0);
      @(negedge clk);
    end
    agent_hold = 1'b0;
    @(negedge clk);
    if (exp_width(m) == 0) begin
      s_valid = 1'b1;
      for (int i = 0; i < 20; i++) begin
        chk("R5 invalid mode never loads", int'(s_ready || done), 0);
        @(negedge clk);
      end
      s_valid = 1'b0;
      return;
    end
    chk("R3 load starts", int'(s_ready), 1);
    if (flip) mode_pins = (exp_width(m) == 8) ? 3'b000 : 3'b011;
    acc = 0; guard = 0;
    while (acc < exp_beats(m) && guard < 20000) begin
      if (abort > 0 && acc >= abort) begin
        s_valid = 1'b0; restart = 1'b1;
        @(negedge clk); restart = 1'b0;
        chk("R10 restart mid-load", int'(init_drive_low && !s_ready), 1);
        return;
      end
      s_valid = ($urandom % 4) != 0;
      s_data0 = $urandom % 2;
      if (s_valid && s_ready) acc++;
      guard++;
      @(negedge clk);
    end
    s_valid = 1'b0;
    chk("R6 beat count", acc, exp_beats(m));
    chk(flip ? "R4 latched width" : "R6 ready low after last beat", int'(s_ready), 0);
    chk("R6 no gsr before completion seen", int'(gsr_pulse), 0);
    @(negedge clk);
    chk("R7 gsr pulse", int'(gsr_pulse), 1);
    chk("R7 done not yet", int'(done), 0);
    @(negedge clk);
    chk("R7 gsr single", int'(gsr_pulse), 0);
    chk("R7 done up", int'(done), 1);
    chk("R8 gts held at done", int'(gts_hold), 1);
    if (sync) begin
      for (int i = 0; i < ext_delay; i++) begin
        chk("R9 wait for ext done", int'(gts_hold), 1);
        @(negedge clk);
      end
      ext_done_in = 1'b1;
    end
    @(negedge clk);
    chk("R8 gts released", int'(gts_hold), 0);
    chk("R8 gwe still held", int'(gwe_hold), 1);
    @(negedge clk);
    chk("R8 gwe released", int'(gwe_hold), 0);
    chk("R11 ready after load", int'(s_ready), exp_serial(m));
    bit_v = $urandom % 2;
    s_valid = 1'b1; s_data0 = bit_v[0];
    @(negedge clk);
    s_valid = 1'b0;
    chk("R11 thru valid", int'(thru_valid), exp_serial(m));
    if (exp_serial(m) == 1) chk("R11 thru bit", int'(thru_bit), bit_v);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    logic [2:0] modes [5];
    int seed;
    modes[0] = 3'b000; modes[1] = 3'b111; modes[2] = 3'b011;
    modes[3] = 3'b110; modes[4] = 3'b101;
    seed = $urandom(32'h5EED);
    chk("R1 reset init low", int'(init_drive_low), 1);
    chk("R1 reset outputs", int'(done || gsr_pulse || s_ready), 0);
    chk("R1 reset holds", int'(gts_hold && gwe_hold), 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 clear after reset", int'(init_drive_low && gts_hold && gwe_hold && !done), 1);

    run_cfg(3'b000, 0, 0, 0, 0, 0, 0);
    run_cfg(3'b110, 1, 3, 4, 0, 0, 0);
    run_cfg(3'b011, 0, 0, 0, 1, 0, 0);
    run_cfg(3'b000, 0, 0, 0, 1, 0, 0);
    run_cfg(3'b101, 1, 0, 0, 0, 0, 0);
    run_cfg(3'b111, 0, 2, 0, 0, 0, 0);
    run_cfg(3'b001, 0, 0, 0, 0, 0, 0);
    run_cfg(3'b100, 0, 0, 0, 0, 0, 0);
    run_cfg(3'b011, 0, 0, 0, 0, 7, 0);
    run_cfg(3'b011, 0, 0, 0, 0, 0, 1);
    for (int r = 0; r < 8; r++)
      run_cfg(modes[$urandom % 5], bit'($urandom % 2), $urandom % 6,
              $urandom % 5, bit'($urandom % 2), 0, 0);
    finish_run();
  end
endmodule